// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block corrects an 8-bit accumulator after a binary add or subtract so that it holds packed two-digit BCD. A caller presents the accumulator, its carry and half-carry flags, a direction select and a valid strobe. One clock later the unit returns the corrected accumulator, the updated carry, and fresh negative and zero flags, together with a valid strobe. The half-carry and overflow flags leave the unit exactly as they entered.

The rule is applied the same way to every input, including accumulator values that are not valid BCD. The high-digit decision is taken on the raw accumulator value. The low-digit decision is taken on the raw low nibble. Subtract mode treats carry as an inverted borrow: a clear carry means a borrow happened.

Top module: `bcd_adjust_unit`

## Requirements
- R1: With `add_sel`=1 and (`c_in`=1 or `acc_in` > 8'h99), 8'h60 is added to the accumulator modulo 256 and `c_out` is 1.
- R2: With `add_sel`=1 and (`h_in`=1 or `acc_in[3:0]` > 9), 8'h06 is added modulo 256. This decision uses the unmodified low nibble.
- R3: With `add_sel`=0 and (`c_in`=0 or `acc_in` > 8'h99), 8'h60 is subtracted modulo 256 and `c_out` is 0.
- R4: With `add_sel`=0 and (`h_in`=0 or `acc_in[3:0]` > 9), 8'h06 is subtracted modulo 256.
- R5: When the high-digit condition of the selected mode does not hold, `c_out` equals `c_in`.
- R6: `n_out` equals bit 7 of the final result. `z_out` is 1 exactly when the final result is 8'h00.
- R7: `h_out` equals `h_in` and `v_out` equals `v_in`.
- R8: `vld_out` equals `vld_in` delayed by one cycle. Output data is registered one cycle after the input is presented.
- R9: While `rst` is high, `vld_out` is 0 and all output data and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_in | input | 1 | Input strobe |
| add_sel | input | 1 | 1 = adjust after add, 0 = adjust after subtract |
| acc_in | input | 8 | Accumulator before adjustment |
| c_in | input | 1 | Carry flag in |
| h_in | input | 1 | Half-carry flag in |
| v_in | input | 1 | Overflow flag in, passed through |
| vld_out | output | 1 | Output strobe |
| acc_out | output | 8 | Adjusted accumulator |
| c_out | output | 1 | Carry flag out |
| h_out | output | 1 | Half-carry flag out |
| v_out | output | 1 | Overflow flag out |
| n_out | output | 1 | Negative flag of the result |
| z_out | output | 1 | Zero flag of the result |

## Verification
Vectors cover every combination of carry and half-carry in both directions, applied to valid BCD values, values just above 8'h99, and a low nibble above 9. These separate the flag-driven corrections from the value-driven ones. Non-BCD inputs such as 8'hFF and 8'h9A exercise wraparound and confirm that the high-digit test reads the raw value. Zero and negative results, and the pass-through of H and V, are checked in both modes. Gaps in the valid strobe and an assertion of reset show the one-cycle latency and the cleared state.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam logic [DW-1:0] HI_STEP  = 8'h60;
    localparam logic [DW-1:0] LO_STEP  = 8'h06;
    localparam logic [DW-1:0] HI_LIMIT = 8'h99;
    localparam logic [NW-1:0] LO_LIMIT = 4'd9;

    typedef enum logic { DIR_SUB = 1'b0, DIR_ADD = 1'b1 } dir_e;

    typedef struct packed {
        logic c;
        logic h;
        logic v;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] acc;
        flags_t        fl;
    } result_t;

    function automatic logic [DW-1:0] step_apply(input logic [DW-1:0] a,
                                                 input logic [DW-1:0] s,
                                                 input dir_e d);
        return (d == DIR_ADD) ? a + s : a - s;
    endfunction
endpackage

// File: rtl/bcd_digit_decide.sv
module bcd_digit_decide
    import bcd_adj_pkg::*;
(
    input  dir_e          dir,
    input  logic [DW-1:0] acc,
    input  logic          c_flag,
    input  logic          h_flag,
    output logic          fix_hi,
    output logic          fix_lo
);
    logic c_act, h_act;
    always_comb begin
        c_act  = (dir == DIR_ADD) ? c_flag : ~c_flag;
        h_act  = (dir == DIR_ADD) ? h_flag : ~h_flag;
        fix_hi = c_act | (acc > HI_LIMIT);
        fix_lo = h_act | (acc[NW-1:0] > LO_LIMIT);
    end
endmodule

// File: rtl/bcd_correct_path.sv
module bcd_correct_path
    import bcd_adj_pkg::*;
(
    input  dir_e          dir,
    input  logic [DW-1:0] acc,
    input  logic          fix_hi,
    input  logic          fix_lo,
    output logic [DW-1:0] res
);
    logic [DW-1:0] mid;
    always_comb begin
        mid = fix_hi ? step_apply(acc, HI_STEP, dir) : acc;
        res = fix_lo ? step_apply(mid, LO_STEP, dir) : mid;
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_in,
    input  logic          add_sel,
    input  logic [7:0]    acc_in,
    input  logic          c_in,
    input  logic          h_in,
    input  logic          v_in,
    output logic          vld_out,
    output logic [7:0]    acc_out,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out,
    output logic          n_out,
    output logic          z_out
);
    dir_e          dir;
    logic          fix_hi, fix_lo;
    logic [DW-1:0] res;
    result_t       nxt, q;

    assign dir = dir_e'(add_sel);

    bcd_digit_decide u_dec (
        .dir(dir), .acc(acc_in), .c_flag(c_in), .h_flag(h_in),
        .fix_hi(fix_hi), .fix_lo(fix_lo)
    );

    bcd_correct_path u_cor (
        .dir(dir), .acc(acc_in), .fix_hi(fix_hi), .fix_lo(fix_lo), .res(res)
    );

    always_comb begin
        nxt.vld  = vld_in;
        nxt.acc  = res;
        nxt.fl.c = fix_hi ? (dir == DIR_ADD) : c_in;
        nxt.fl.h = h_in;
        nxt.fl.v = v_in;
        nxt.fl.n = res[DW-1];
        nxt.fl.z = (res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign vld_out = q.vld;
    assign acc_out = q.acc;
    assign c_out   = q.fl.c;
    assign h_out   = q.fl.h;
    assign v_out   = q.fl.v;
    assign n_out   = q.fl.n;
    assign z_out   = q.fl.z;
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       vld_in,
    input logic       add_sel,
    input logic [7:0] acc_in,
    input logic       c_in,
    input logic       h_in,
    input logic       v_in,
    input logic       vld_out,
    input logic [7:0] acc_out,
    input logic       c_out,
    input logic       h_out,
    input logic       v_out,
    input logic       n_out,
    input logic       z_out
);
    p_vld_delay_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> vld_out == $past(vld_in));
    p_h_v_pass_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (h_out == $past(h_in)) && (v_out == $past(v_in)));
    p_add_carry_set_r1: assert property (@(posedge clk) disable iff (rst)
        (add_sel && (c_in || acc_in > 8'h99)) |=> c_out);
    p_sub_carry_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (!add_sel && (!c_in || acc_in > 8'h99)) |=> !c_out);
    p_carry_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_in <= 8'h99 && (add_sel ? !c_in : c_in)) |=> c_out == $past(c_in));
    p_nz_flags_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (n_out == acc_out[7]) && (z_out == (acc_out == 8'h00)));
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (.*);

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic clk = 0, rst = 1, vld_in = 0, add_sel = 0, c_in = 0, h_in = 0, v_in = 0;
    logic [7:0] acc_in = 0;
    logic vld_out, c_out, h_out, v_out, n_out, z_out;
    logic [7:0] acc_out;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_adjust_unit dut (.*);

    // {add, acc, c, h}
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 8'h45, 1'b0, 1'b0}, {1'b1, 8'h4A, 1'b0, 1'b0},
        {1'b1, 8'h9A, 1'b0, 1'b0}, {1'b1, 8'hA0, 1'b0, 1'b0},
        {1'b1, 8'h12, 1'b1, 1'b0}, {1'b1, 8'h12, 1'b0, 1'b1},
        {1'b1, 8'hFF, 1'b0, 1'b0}, {1'b1, 8'h9A, 1'b1, 1'b1},
        {1'b1, 8'h00, 1'b0, 1'b0}, {1'b1, 8'hA0, 1'b1, 1'b0},
        {1'b0, 8'h45, 1'b1, 1'b1}, {1'b0, 8'h45, 1'b0, 1'b1},
        {1'b0, 8'h45, 1'b1, 1'b0}, {1'b0, 8'h4C, 1'b1, 1'b1},
        {1'b0, 8'hA5, 1'b1, 1'b1}, {1'b0, 8'h00, 1'b0, 1'b0},
        {1'b0, 8'h66, 1'b0, 1'b0}, {1'b0, 8'h06, 1'b1, 1'b0},
        {1'b0, 8'h9A, 1'b1, 1'b1}, {1'b0, 8'hFF, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input logic a, input logic [7:0] x, input logic c, input logic h,
                         output logic [7:0] r, output logic co);
        logic hi, lo;
        hi = (a ? c : !c) || x > 8'h99;
        lo = (a ? h : !h) || x[3:0] > 4'd9;
        r = x; co = c;
        if (hi) begin r = a ? r + 8'h60 : r - 8'h60; co = a; end
        if (lo) r = a ? r + 8'h06 : r - 8'h06;
    endtask

    initial begin
        #(CLK_PERIOD*2000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] er; logic ec;
        @(posedge clk); @(posedge clk);
        #1;
        chk("R9 vld", vld_out, 0);
        chk("R9 data", {acc_out, c_out, h_out, v_out, n_out, z_out}, 0);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {add_sel, acc_in, c_in, h_in} = VEC[i];
            v_in = i[0];
            vld_in = 1;
            @(posedge clk); #1;
            model(add_sel, acc_in, c_in, h_in, er, ec);
            chk(add_sel ? "R1/R2 acc" : "R3/R4 acc", acc_out, er);
            chk(add_sel ? "R1 R5 carry" : "R3 R5 carry", c_out, ec);
            chk("R6 n", n_out, er[7]);
            chk("R6 z", z_out, er == 8'h00);
            chk("R7 hv", {h_out, v_out}, {h_in, v_in});
            chk("R8 vld", vld_out, 1);
        end
        // directed corners
        @(negedge clk); add_sel = 1; acc_in = 8'h9A; c_in = 0; h_in = 0; vld_in = 0;
        @(posedge clk); #1;
        chk("R1 9A->00", acc_out, 8'h00); chk("R1 carry", c_out, 1);
        chk("R6 z", z_out, 1); chk("R8 vld low", vld_out, 0);
        @(negedge clk); add_sel = 0; acc_in = 8'h00; c_in = 0; h_in = 0; vld_in = 1;
        @(posedge clk); #1;
        chk("R3/R4 00->9A", acc_out, 8'h9A); chk("R3 carry", c_out, 0); chk("R6 n", n_out, 1);
        @(negedge clk); add_sel = 1; acc_in = 8'h38; c_in = 0; h_in = 0;
        @(posedge clk); #1;
        chk("R5 keep", {acc_out, c_out}, {8'h38, 1'b0});
        @(negedge clk); add_sel = 0; acc_in = 8'h38; c_in = 1; h_in = 1;
        @(posedge clk); #1;
        chk("R5 keep sub", {acc_out, c_out}, {8'h38, 1'b1});
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        chk("R9 reset again", {vld_out, acc_out, c_out, h_out}, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule